// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is the serial control front end of a small power-management device. It connects to a two-wire I2C bus and gives an external master access to an eight-entry byte register bank. SCL and SDA are sampled in the system clock domain. Each line passes through a synchronizer and a short majority-free glitch filter. The filtered lines then feed START, repeated START, STOP and clock-edge detectors.

The block answers only to its fixed 7-bit bus address. In a write transfer, the first byte after the address byte loads an internal register pointer, and every later byte is stored at that pointer. In a read transfer, bytes are returned starting from the pointer. The pointer advances after every data byte in either direction and wraps inside the eight-entry window. A read issued straight after the address byte therefore continues from the entry after the last one touched. A combined transfer sets the pointer, then switches to reading through a repeated START. The register bank itself sits outside the block. The block drives a write strobe with address and data, and it takes read data back for the address it presents.

A separate active-low bus reset pin forces both bus inputs to idle-high and holds the engine idle, so nothing on the wires reaches the logic while it is low.

Top module: `i2cRegTarget`

## Requirements
- R1: Only the address byte whose upper seven bits equal 0001001b (0x12 for write, 0x13 for read) is acknowledged. Any other address leaves SDA released during the ninth clock, and the block ignores every byte until the next START: no write strobe, no SDA drive, and the pointer is unchanged.
- R2: In a write transfer (address bit 0 = 0), the first byte after the address loads the pointer from its low three bits. Each following byte produces one write strobe at the current pointer with that byte as data, and the pointer then advances by one.
- R3: The pointer wraps from 7 to 0 when it advances. This applies to both writes and reads.
- R4: In a read transfer (address bit 0 = 1), the first byte returned is the register at the pointer, sent MSB first, and the pointer then advances by one. A read with no preceding pointer byte therefore returns the entry after the last one accessed.
- R5: A repeated START with the read bit, following a pointer write, returns data beginning at the pointer just written.
- R6: The block pulls SDA low for the whole ninth clock after a matching address byte and after each received write byte. It changes its SDA drive only while SCL is low.
- R7: A master ACK during a read makes the block send the next byte. A master NACK makes the block release SDA and return to idle, and the pointer keeps the advance made for the NACKed byte.
- R8: While `busRstN` is low, the block never pulls SDA, issues no write strobe, and holds the pointer at 0.
- R9: After reset, `sdaOe` and `regWrEn` are 0 and `regAddr` is 0. A STOP, including one that follows an address byte with no data, returns the block to idle without changing the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low system reset |
| busRstN | input | 1 | Active-low bus reset; gates SCL/SDA to idle and holds the engine idle |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low (ACK or a 0 data bit), 0 releases it |
| regWrEn | output | 1 | One-cycle write strobe to the register bank |
| regAddr | output | 3 | Current pointer; write address and read address |
| regWrData | output | 8 | Byte to write when `regWrEn` is 1 |
| regRdData | input | 8 | Register bank contents at `regAddr` |

## Verification
The hardest states to reach from the ports are the pointer wrap and a read that has no address phase. Both need an earlier transfer that leaves the pointer at a known place. The bench builds them from chained transfers: a write placing two bytes at pointer 7, a combined read that crosses 7 into 0, and bare reads that continue from where an earlier transfer stopped. The bus-reset case is reached by running a complete, well-formed write while `busRstN` is low. After release, a bare read returns entry 0 with its old contents, which proves that both the pointer reset and the ignored write took effect.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic shiftIn;   // capture SDA into the receive shifter
    logic ptrLoad;   // load pointer from received byte
    logic wrStrobe;  // write received byte at pointer, then advance
    logic rdLoad;    // fetch read byte at pointer, then advance
    logic shiftOut;  // present next transmit bit
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKA, ST_RXB, ST_ACKW, ST_TXB, ST_MACK
  } tgtState_t;

endpackage

// File: rtl/i2cBusSampler.sv
module i2cBusSampler #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclFilt,
  output logic sdaFilt,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [1:0] rawIn;
  logic [1:0] filtOut;
  logic       sclPrev, sdaPrev;

  assign rawIn = {sdaRaw, sclRaw};

  // Per line: two-flop synchronizer, then a filter that only moves once
  // FILT_LEN consecutive samples agree.
  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [1:0]          syncQ;
    logic [FILT_LEN-1:0] histQ;
    logic                filtQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        histQ <= '1;
        filtQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[i]};
        histQ <= {histQ[FILT_LEN-2:0], syncQ[1]};
        if (&histQ)       filtQ <= 1'b1;
        else if (~|histQ) filtQ <= 1'b0;
      end
    end
    assign filtOut[i] = filtQ;
  end

  assign sclFilt = filtOut[0];
  assign sdaFilt = filtOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclFilt;
      sdaPrev <= sdaFilt;
    end
  end

  assign sclRise  = sclFilt & ~sclPrev;
  assign sclFall  = ~sclFilt & sclPrev;
  assign startDet = sclFilt & sclPrev & sdaPrev & ~sdaFilt;
  assign stopDet  = sclFilt & sclPrev & ~sdaPrev & sdaFilt;
endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h09
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busHeld,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        sclFilt,
  input  logic        sdaFilt,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic [7:0]  rxByte,
  input  logic        txBit,
  output ctlStrobes_t strobes,
  output logic        sdaOe
);
  tgtState_t  state;
  logic [3:0] bitCnt;
  logic       ptrPhase, rwBit, mAck;
  logic       byteDone;

  assign byteDone = (bitCnt == 4'd8);

  always_comb begin
    strobes = '0;
    if (!busHeld) begin
      strobes.shiftIn  = sclRise && (state == ST_ADDR || state == ST_RXB);
      strobes.ptrLoad  = sclFall && state == ST_RXB && byteDone && ptrPhase;
      strobes.wrStrobe = sclFall && state == ST_RXB && byteDone && !ptrPhase;
      strobes.rdLoad   = sclFall && ((state == ST_ACKA && rwBit) ||
                                     (state == ST_MACK && mAck));
      strobes.shiftOut = sclFall && state == ST_TXB && !byteDone;
    end
  end

  assign sdaOe = (state == ST_ACKA) || (state == ST_ACKW) ||
                 (state == ST_TXB && !txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ptrPhase <= 1'b0;
      rwBit    <= 1'b0;
      mAck     <= 1'b0;
    end else if (busHeld) begin
      state <= ST_IDLE;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && byteDone) begin
            if (rxByte[7:1] == TGT_ADDR) begin
              state <= ST_ACKA;
              rwBit <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACKA: if (sclFall) begin
          bitCnt <= '0;
          if (rwBit) state <= ST_TXB;
          else begin
            state    <= ST_RXB;
            ptrPhase <= 1'b1;
          end
        end
        ST_RXB: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && byteDone) begin
            state    <= ST_ACKW;
            ptrPhase <= 1'b0;
          end
        end
        ST_ACKW: if (sclFall) begin
          state  <= ST_RXB;
          bitCnt <= '0;
        end
        ST_TXB: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && byteDone) state <= ST_MACK;
        end
        ST_MACK: begin
          if (sclRise) mAck <= ~sdaFilt;
          else if (sclFall) begin
            if (mAck) begin
              state  <= ST_TXB;
              bitCnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the block may move SDA only while the clock line is low.
  assert_sda_moves_in_low_R6: assert property (@(posedge clk)
    disable iff (!rstN || busHeld) !$stable(sdaOe) |-> !sclFilt);

endmodule

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cTgtPkg::*;
#(
  parameter int REG_COUNT = 8,
  localparam int PTR_W = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busHeld,
  input  ctlStrobes_t      strobes,
  input  logic             sdaFilt,
  input  logic [7:0]       regRdData,
  output logic [7:0]       rxByte,
  output logic             txBit,
  output logic [PTR_W-1:0] ptr,
  output logic             regWrEn,
  output logic [7:0]       regWrData
);
  logic [7:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '1;
      ptr     <= '0;
    end else begin
      if (strobes.shiftIn) rxByte <= {rxByte[6:0], sdaFilt};
      if (strobes.rdLoad)        txShift <= regRdData;
      else if (strobes.shiftOut) txShift <= {txShift[6:0], 1'b1};
      if (busHeld)                                ptr <= '0;
      else if (strobes.ptrLoad)                   ptr <= rxByte[PTR_W-1:0];
      else if (strobes.wrStrobe || strobes.rdLoad) ptr <= ptr + 1'b1;
    end
  end

  assign txBit     = txShift[7];
  assign regWrEn   = strobes.wrStrobe;
  assign regWrData = rxByte;

  // R3: each data byte moves the pointer by exactly one, modulo the window.
  assert_ptr_step_R3: assert property (@(posedge clk)
    disable iff (!rstN || busHeld)
    (strobes.wrStrobe || strobes.rdLoad) |=> ptr == PTR_W'($past(ptr) + 1'b1));

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR  = 7'h09,
  parameter int         REG_COUNT = 8,
  parameter int         FILT_LEN  = 3,
  localparam int        PTR_W     = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busRstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  input  logic [7:0]       regRdData
);
  logic [1:0]  busSync;
  logic        busHeld;
  logic        sclFilt, sdaFilt, sclRise, sclFall, startDet, stopDet;
  logic [7:0]  rxByte;
  logic        txBit;
  ctlStrobes_t strobes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busSync <= '0;
    else       busSync <= {busSync[0], busRstN};
  end
  assign busHeld = ~busSync[1];

  i2cBusSampler #(.FILT_LEN(FILT_LEN)) i_sampler (
    .clk(clk), .rstN(rstN),
    .sclRaw(sclIn | ~busRstN), .sdaRaw(sdaIn | ~busRstN),
    .sclFilt(sclFilt), .sdaFilt(sdaFilt), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cTgtCtrl #(.TGT_ADDR(TGT_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .busHeld(busHeld),
    .sclRise(sclRise), .sclFall(sclFall), .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte), .txBit(txBit),
    .strobes(strobes), .sdaOe(sdaOe)
  );

  i2cTgtData #(.REG_COUNT(REG_COUNT)) i_data (
    .clk(clk), .rstN(rstN), .busHeld(busHeld), .strobes(strobes),
    .sdaFilt(sdaFilt), .regRdData(regRdData), .rxByte(rxByte), .txBit(txBit),
    .ptr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData)
  );

  // R9: a STOP leaves the pointer where it was.
  assert_stop_keeps_ptr_R9: assert property (@(posedge clk)
    disable iff (!rstN || busHeld) stopDet |=> regAddr == $past(regAddr));

  // R8: a held bus neither drives SDA nor writes, and the pointer sits at 0.
  assert_held_quiet_R8: assert property (@(posedge clk)
    disable iff (!rstN)
    (busHeld && $past(busHeld)) |-> (!sdaOe && !regWrEn && regAddr == '0));

endmodule

// File: tb/test_i2cRegTarget.sv
module test_i2cRegTarget;
  localparam int Q = 10;  // clocks per quarter SCL period
  localparam logic [23:0] VEC [4] = '{24'h02A53C, 24'h07817E, 24'h0500FF, 24'h0B5AC3};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busRstN = 1'b1;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaOe, regWrEn;
  logic [2:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] rf [8];
  logic [7:0] expMem [8];
  int         checks = 0, errors = 0, wrCount = 0;
  wire        sdaLine = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  i2cRegTarget i_i2cRegTarget (
    .clk(clk), .rstN(rstN), .busRstN(busRstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  // Register bank model.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else if (regWrEn) begin
      rf[regAddr] <= regWrData;
      wrCount     <= wrCount + 1;
    end
  end
  assign regRdData = rf[regAddr];

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic seen);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    seen = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], s);
    sendBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sendBit(1'b1, s);
      d[i] = s;
    end
    sendBit(~mAck, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         w0;
    for (int i = 0; i < 8; i++) expMem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    checkEq("R9 reset sdaOe", {7'b0, sdaOe}, 8'h00);
    checkEq("R9 reset regWrEn", {7'b0, regWrEn}, 8'h00);
    checkEq("R9 reset regAddr", {5'b0, regAddr}, 8'h00);

    // Vector table: write two bytes at a pointer, then read them back
    // through a combined transfer.
    for (int v = 0; v < 4; v++) begin
      logic [7:0] p, d0, d1;
      logic [2:0] b0, b1, b2;
      {p, d0, d1} = VEC[v];
      b0 = p[2:0]; b1 = b0 + 3'd1; b2 = b0 + 3'd2;
      startCond();
      writeByte(8'h12, ack); checkEq("R6 R1 address ack on write", {7'b0, ack}, 8'h01);
      writeByte(p, ack);     checkEq("R6 pointer byte ack", {7'b0, ack}, 8'h01);
      writeByte(d0, ack);    checkEq("R6 data byte ack", {7'b0, ack}, 8'h01);
      writeByte(d1, ack);
      stopCond();
      expMem[b0] = d0; expMem[b1] = d1;
      checkEq("R2 R3 pointer after two writes", {5'b0, regAddr}, {5'b0, b2});
      startCond();
      writeByte(8'h12, ack);
      writeByte(p, ack);
      startCond();
      writeByte(8'h13, ack); checkEq("R5 read address ack after repeated START", {7'b0, ack}, 8'h01);
      readByte(1'b1, d);     checkEq("R5 R4 first read byte at pointer", d, expMem[b0]);
      readByte(1'b0, d);     checkEq("R3 R4 second read byte", d, expMem[b1]);
      stopCond();
      checkEq("R4 pointer after two reads", {5'b0, regAddr}, {5'b0, b2});
    end

    // R4: bare read continues after last access (pointer is 5 here).
    startCond();
    writeByte(8'h13, ack);
    readByte(1'b1, d); checkEq("R4 bare read entry 5", d, expMem[5]);
    readByte(1'b0, d); checkEq("R4 bare read entry 6", d, expMem[6]);
    stopCond();
    startCond();
    writeByte(8'h13, ack);
    readByte(1'b0, d); checkEq("R4 bare read entry 7", d, expMem[7]);
    stopCond();
    checkEq("R3 read wraps pointer to 0", {5'b0, regAddr}, 8'h00);

    // R9: STOP right after the address byte keeps the pointer.
    startCond();
    writeByte(8'h12, ack);
    stopCond();
    checkEq("R9 STOP after address keeps pointer", {5'b0, regAddr}, 8'h00);
    startCond();
    writeByte(8'h12, ack);
    writeByte(8'h04, ack);
    stopCond();
    checkEq("R2 pointer-only write", {5'b0, regAddr}, 8'h04);

    // R1: foreign addresses are ignored.
    w0 = wrCount;
    startCond();
    writeByte(8'h26, ack); checkEq("R1 foreign write address not acked", {7'b0, ack}, 8'h00);
    writeByte(8'h55, ack); checkEq("R1 byte after foreign address not acked", {7'b0, ack}, 8'h00);
    stopCond();
    startCond();
    writeByte(8'h27, ack); checkEq("R1 foreign read address not acked", {7'b0, ack}, 8'h00);
    readByte(1'b0, d);     checkEq("R1 no data driven for foreign read", d, 8'hFF);
    stopCond();
    checkEq("R1 no write strobe", 8'(wrCount - w0), 8'h00);
    checkEq("R1 pointer unchanged", {5'b0, regAddr}, 8'h04);

    // R7: NACK ends the read and releases SDA.
    startCond();
    writeByte(8'h13, ack);
    readByte(1'b0, d);     checkEq("R7 read before NACK", d, expMem[4]);
    @(negedge clk);
    checkEq("R7 SDA released after NACK", {7'b0, sdaOe}, 8'h00);
    stopCond();
    checkEq("R7 pointer advanced past NACKed byte", {5'b0, regAddr}, 8'h05);

    // R8: bus reset held low during a complete write.
    busRstN = 1'b0;
    w0 = wrCount;
    repeat (8) @(negedge clk);
    checkEq("R8 pointer held at 0", {5'b0, regAddr}, 8'h00);
    startCond();
    writeByte(8'h12, ack); checkEq("R8 no ack while held", {7'b0, ack}, 8'h00);
    writeByte(8'h00, ack);
    writeByte(8'h99, ack);
    stopCond();
    checkEq("R8 no write while held", 8'(wrCount - w0), 8'h00);
    busRstN = 1'b1;
    repeat (16) @(negedge clk);
    startCond();
    writeByte(8'h13, ack);
    readByte(1'b0, d);     checkEq("R8 entry 0 untouched, read from 0", d, expMem[0]);
    stopCond();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule